// File: doc/BRIEF.md
# Non-Audio Payload Sync Detector

This block sits beside the received sample path of a digital audio receiver. It watches the 16-bit words recovered from the incoming subframes and looks for the six-word burst preamble that compressed payloads carry. Some encoders leave the channel-status "not audio" bit clear, so the receiver cannot rely on that bit alone. When the preamble is found, the block raises an auto-detect flag. The flag stays up while preambles keep arriving. It drops once a fixed number of frames pass with no new preamble.

The reported non-audio indication merges the auto-detect flag with the received channel-status bit 1. Downstream logic can then mute or reroute the samples. The words themselves pass through unchanged, and the block never edits the audio.

Top module: `nonaudio_sync_detect`

## Requirements
- R1: A synchronous active-high reset clears the auto-detect flag, the sync pulse, the frame counter and any partly matched preamble. Words seen before the reset never count toward a later match.
- R2: `sync_pulse` goes high for exactly one clock, in the cycle after the edge that accepts the final word of this sequence of valid words: 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F. Cycles with `word_valid` low are skipped and do not break the sequence.
- R3: `auto_det` rises at the same edge as `sync_pulse`, and at no other time.
- R4: A zero run longer than four words before 0xF872 still completes a match.
- R5: A word that breaks the sequence restarts matching. If that breaking word is 0x0000, it counts as the first zero of a new run.
- R6: With no new match, `auto_det` falls at the edge that accepts the 4096th `frame_strobe` after the last match. Strobes arriving while `auto_det` is low have no effect.
- R7: Each match reloads the frame count. When a match and a `frame_strobe` arrive in the same cycle, the strobe is not counted.
- R8: `nonaudio` is high exactly when `auto_det` is high or `cs_bit1` is high in the same cycle.
- R9: `word_out` equals `word_in` in every cycle.
- R10: After a match, a new match needs six fresh valid words. The trailing words of the previous match are not reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 16 | Received audio word, one per subframe |
| word_valid | input | 1 | Qualifies `word_in` |
| frame_strobe | input | 1 | One-cycle strobe per received frame |
| cs_bit1 | input | 1 | Received channel-status bit 1 |
| word_out | output | 16 | Unmodified copy of `word_in` |
| auto_det | output | 1 | Preamble auto-detect flag |
| nonaudio | output | 1 | `auto_det` OR `cs_bit1` |
| sync_pulse | output | 1 | One-clock pulse per detected preamble |

## Verification
A corrupted tracker state shows up within one clock of the 0x4E1F word. It appears either as a missed `sync_pulse` or as a pulse after an incomplete sequence, and `auto_det` moves with it. A wrong frame count is silent until the timeout edge, 4096 strobes later. There `auto_det` falls one strobe early or late, so the bench runs full-length windows both with and without a mid-window re-arm. A reference model predicts every output on every clock, which also catches a pass-through word that is altered in any cycle.

// File: rtl/nad_pkg.sv
package nad_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t MARK_FIRST  = 16'hF872;
    localparam word_t MARK_SECOND = 16'h4E1F;
endpackage

// File: rtl/nad_matcher.sv
module nad_matcher
    import nad_pkg::*;
#(
    parameter int ZERO_RUN = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t word,
    input  logic  valid,
    output logic  hit,
    output logic  pulse
);
    localparam int ZW = $clog2(ZERO_RUN + 1);
    localparam logic [ZW-1:0] ZFULL = ZW'(ZERO_RUN);

    typedef struct packed {
        logic [ZW-1:0] zeros;
        logic          got_mark;
        logic          pulse;
    } trk_t;

    trk_t trk_d, trk_q;
    logic hit_d;

    always_comb begin
        trk_d       = trk_q;
        trk_d.pulse = 1'b0;
        hit_d       = 1'b0;
        if (valid) begin
            if (trk_q.got_mark) begin
                trk_d.got_mark = 1'b0;
                if (word == MARK_SECOND) begin
                    hit_d       = 1'b1;
                    trk_d.pulse = 1'b1;
                    trk_d.zeros = '0;
                end else if (word == '0) begin
                    trk_d.zeros = ZW'(1);
                end else begin
                    trk_d.zeros = '0;
                end
            end else if (trk_q.zeros == ZFULL) begin
                if (word == '0) begin
                    trk_d.zeros = ZFULL;
                end else if (word == MARK_FIRST) begin
                    trk_d.got_mark = 1'b1;
                    trk_d.zeros    = '0;
                end else begin
                    trk_d.zeros = '0;
                end
            end else begin
                if (word == '0) begin
                    trk_d.zeros = trk_q.zeros + ZW'(1);
                end else begin
                    trk_d.zeros = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign hit   = hit_d;
    assign pulse = trk_q.pulse;
endmodule

// File: rtl/nad_hold_timer.sv
module nad_hold_timer #(
    parameter int TIMEOUT_FRAMES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic rearm,
    input  logic frame_tick,
    output logic active
);
    localparam int CNT_W = $clog2(TIMEOUT_FRAMES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_FRAMES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rearm) begin
            tmr_d.cnt    = '0;
            tmr_d.active = 1'b1;
        end else if (frame_tick && tmr_q.active) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt    = '0;
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active = tmr_q.active;
endmodule

// File: rtl/nonaudio_sync_detect.sv
module nonaudio_sync_detect
    import nad_pkg::*;
#(
    parameter int ZERO_RUN       = 4,
    parameter int TIMEOUT_FRAMES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] word_in,
    input  logic        word_valid,
    input  logic        frame_strobe,
    input  logic        cs_bit1,
    output logic [15:0] word_out,
    output logic        auto_det,
    output logic        nonaudio,
    output logic        sync_pulse
);
    logic match_hit;

    nad_matcher #(
        .ZERO_RUN (ZERO_RUN)
    ) matcher_i (
        .clk   (clk),
        .rst   (rst),
        .word  (word_in),
        .valid (word_valid),
        .hit   (match_hit),
        .pulse (sync_pulse)
    );

    nad_hold_timer #(
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .rearm      (match_hit),
        .frame_tick (frame_strobe),
        .active     (auto_det)
    );

    assign nonaudio = auto_det | cs_bit1;
    assign word_out = word_in;
endmodule

// File: rtl/nad_checker.sv
module nad_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] word_in,
    input logic        word_valid,
    input logic        frame_strobe,
    input logic        cs_bit1,
    input logic        auto_det,
    input logic        nonaudio,
    input logic        sync_pulse
);
    // R2: the pulse never lasts two clocks
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse);

    // R2: a pulse follows an accepted closing word
    a_r2_after_close: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> $past(word_valid && word_in == 16'h4E1F));

    // R3: the flag is up whenever a pulse is seen
    a_r3_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> auto_det);

    // R3: the flag rises only together with a pulse
    a_r3_rise_on_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(auto_det) |-> sync_pulse);

    // R6: the flag drops only at an accepted frame strobe
    a_r6_fall_on_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(auto_det) |-> $past(frame_strobe));

    // R8: either source forces the merged flag high
    a_r8_cs_forces: assert property (@(posedge clk) disable iff (rst)
        cs_bit1 |-> nonaudio);

    a_r8_det_forces: assert property (@(posedge clk) disable iff (rst)
        auto_det |-> nonaudio);
endmodule

bind nonaudio_sync_detect nad_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .word_in      (word_in),
    .word_valid   (word_valid),
    .frame_strobe (frame_strobe),
    .cs_bit1      (cs_bit1),
    .auto_det     (auto_det),
    .nonaudio     (nonaudio),
    .sync_pulse   (sync_pulse)
);

// File: tb/nonaudio_sync_detect_tb_top.sv
module nonaudio_sync_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] word_in = '0;
    logic        word_valid = 1'b0;
    logic        frame_strobe = 1'b0;
    logic        cs_bit1 = 1'b0;
    logic [15:0] word_out;
    logic        auto_det;
    logic        nonaudio;
    logic        sync_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nonaudio_sync_detect dut_i (
        .clk          (clk),
        .rst          (rst),
        .word_in      (word_in),
        .word_valid   (word_valid),
        .frame_strobe (frame_strobe),
        .cs_bit1      (cs_bit1),
        .word_out     (word_out),
        .auto_det     (auto_det),
        .nonaudio     (nonaudio),
        .sync_pulse   (sync_pulse)
    );

    // behavioural reference: sliding window of valid words, frame tally
    logic [15:0] hist[$];
    logic        m_pulse = 1'b0;
    logic        m_auto  = 1'b0;
    int          m_frames = 0;

    function automatic bit window_matches();
        logic [15:0] pat[6] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                16'hF872, 16'h4E1F};
        if (hist.size() != 6) return 1'b0;
        foreach (pat[i]) if (hist[i] != pat[i]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_pulse  = 1'b0;
            m_auto   = 1'b0;
            m_frames = 0;
        end else begin
            bit hit;
            hit = 1'b0;
            if (word_valid) begin
                hist.push_back(word_in);
                if (hist.size() > 6) void'(hist.pop_front());
                if (window_matches()) begin
                    hit = 1'b1;
                    hist.delete();
                end
            end
            m_pulse = hit;
            if (hit) begin
                m_auto   = 1'b1;
                m_frames = 0;
            end else if (frame_strobe && m_auto) begin
                m_frames = m_frames + 1;
                if (m_frames == 4096) begin
                    m_auto   = 1'b0;
                    m_frames = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (rst) return;
        chk("R2 sync_pulse", {15'd0, sync_pulse}, {15'd0, m_pulse});
        chk("R3 auto_det",   {15'd0, auto_det},   {15'd0, m_auto});
        chk("R8 nonaudio",   {15'd0, nonaudio},   {15'd0, m_auto | cs_bit1});
        chk("R9 word_out",   word_out, word_in);
    endtask

    task automatic step(input logic [15:0] w, input logic v, input logic fs);
        @(negedge clk);
        compare_all();
        word_in      = w;
        word_valid   = v;
        frame_strobe = fs;
    endtask

    task automatic send(input logic [15:0] w);
        step(w, 1'b1, 1'b0);
    endtask

    task automatic send_sync(input logic fs_last);
        repeat (4) send(16'h0000);
        send(16'hF872);
        step(16'h4E1F, 1'b1, fs_last);
    endtask

    task automatic idle();
        step(16'hA5A5, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) idle();
        rst = 1'b0;
        idle();
        chk("R1 auto_det after reset", {15'd0, auto_det}, 16'd0);
        chk("R1 pulse after reset", {15'd0, sync_pulse}, 16'd0);

        // R1: a partial sequence does not survive reset
        send(16'h0000); send(16'h0000); send(16'h0000); send(16'h0000);
        rst = 1'b1; idle(); rst = 1'b0;
        send(16'hF872); send(16'h4E1F); idle();
        chk("R1 no match across reset", {15'd0, sync_pulse}, 16'd0);

        // R2: invalid gaps do not break the sequence
        send(16'h0000); idle(); send(16'h0000); send(16'h0000);
        step(16'hF872, 1'b0, 1'b0); send(16'h0000); send(16'hF872);
        idle(); send(16'h4E1F); idle();
        chk("R2 pulse after gapped sequence", {15'd0, sync_pulse}, 16'd1);
        chk("R3 flag with pulse", {15'd0, auto_det}, 16'd1);
        idle();
        chk("R2 pulse lasts one clock", {15'd0, sync_pulse}, 16'd0);

        // R10: old trailing words are not reused
        send(16'hF872); send(16'h4E1F); idle();
        chk("R10 no reuse", {15'd0, sync_pulse}, 16'd0);

        // R4: long zero run
        repeat (7) send(16'h0000);
        send(16'hF872); send(16'h4E1F); idle();
        chk("R4 long run match", {15'd0, sync_pulse}, 16'd1);

        // R5: breaking zero starts a new run
        repeat (4) send(16'h0000);
        send(16'hF872); send(16'h0000); send(16'h0000); send(16'h0000); send(16'h0000);
        send(16'hF872); send(16'h4E1F); idle();
        chk("R5 zero restart match", {15'd0, sync_pulse}, 16'd1);
        send(16'h0000); send(16'h0000); send(16'h0001); send(16'h0000); send(16'h0000);
        send(16'hF872); send(16'h4E1F); idle();
        chk("R5 nonzero break no match", {15'd0, sync_pulse}, 16'd0);

        // R6: timeout after 4096 strobes, R8 merge checked throughout
        send_sync(1'b0); idle();
        cs_bit1 = 1'b1;
        for (int i = 0; i < 4095; i++) step(16'h1234, i[0], 1'b1);
        idle();
        chk("R6 still high after 4095", {15'd0, auto_det}, 16'd1);
        step(16'h0000, 1'b0, 1'b1); idle();
        chk("R6 low after 4096", {15'd0, auto_det}, 16'd0);
        chk("R8 cs alone sets nonaudio", {15'd0, nonaudio}, 16'd1);
        cs_bit1 = 1'b0;
        repeat (10) step(16'h0000, 1'b0, 1'b1);
        idle();
        chk("R6 strobes while low ignored", {15'd0, auto_det}, 16'd0);
        chk("R8 both low", {15'd0, nonaudio}, 16'd0);

        // R7: re-arm mid-window, with strobe on match cycle
        send_sync(1'b0); idle();
        for (int i = 0; i < 3000; i++) step(16'h0000, 1'b0, 1'b1);
        send_sync(1'b1); idle();
        for (int i = 0; i < 4095; i++) step(16'h0000, 1'b0, 1'b1);
        idle();
        chk("R7 rearmed still high", {15'd0, auto_det}, 16'd1);
        step(16'h0000, 1'b0, 1'b1); idle();
        chk("R7 low after full window", {15'd0, auto_det}, 16'd0);

        // R9: arbitrary words pass through
        for (int i = 0; i < 20; i++) step(16'(i * 16'h1F3B), 1'b1, 1'b0);
        idle();
        chk("R9 pass-through", word_out, 16'hA5A5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule